// File: doc/BRIEF.md
# SD Command Line Issuer

This block sends one 48-bit command frame on the command line of an SD or MMC card and collects the card's reply. The controller presents a 6-bit command index, a 32-bit argument, a reply kind, a completion-tag bit and a wait limit, then pulses `fire_i`. The block adds the start and direction bits, computes the 7-bit CRC itself, and shifts the frame out one bit per clock, most significant bit first. The block's clock is the card clock.

Once the end bit has gone out, the block stops driving the line and waits for the card to pull it low. The wait is limited to a programmed number of 16-clock units. A short (48-bit) or long (136-bit) reply is then shifted into a register that the controller reads 16 bits at a time. A status word shows whether the block is idle, whether a reply has arrived, whether the wait ran out, and the tag bit of the command that was last accepted. With the tag, a poller can tell a fresh completion from an older one.

Top module: `sd_cmd_issuer`

## Requirements
- R1: After a synchronous reset, `status_o` reads 0x0001, `cmd_o` is 1, `cmd_oe_o` is 1 and every reply word reads 0.
- R2: A pulse on `fire_i` while idle starts the frame in the next cycle. Over 48 cycles, with `cmd_oe_o` high, the block drives 0, 1, index bits 5..0, argument bits 31..0, CRC bits 6..0 and a final 1, one bit per cycle.
- R3: The CRC uses the polynomial x^7+x^3+1 with a zero start value over the first 40 frame bits. For example, index 0 with argument 0 ends the frame in byte 0x95, index 17 with argument 0 ends it in 0x55, and index 8 with argument 0x1AA ends it in 0x87.
- R4: With reply kind 1 or 2 (3 acts as 2), `cmd_oe_o` drops right after the end bit. The block then samples `cmd_i` for a low start bit during at most max(1, 16*T) cycles, where T is `tmo_units_i` (12 bits, maximum 0xFFF = 65520 cycles).
- R5: If no low bit is seen within that window, status bit 2 (timeout) is set, the block returns to idle and status bit 1 stays 0.
- R6: A reply is the start bit plus 47 more bits (kind 1) or 135 more bits (kind 2). It is shifted in MSB first, one bit per cycle, and status bit 1 (ready) and bit 0 (idle) are set as the last bit is taken. Word n on `rsp_word_o` is reply register bits 16n+15..16n for n = 0..8, and a select above 8 reads 0. The register is cleared when a fire is accepted.
- R7: With reply kind 0, the block does not wait: ready and idle are set right after the end bit.
- R8: Status bit 15 echoes the `toggle_i` value that was latched with the last accepted fire.
- R9: A fire while status bit 0 is clear is ignored. The frame, the echoed tag and the flags are unchanged.
- R10: An accepted fire clears the ready and timeout flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous reset, active high |
| fire_i | input | 1 | Start strobe for one command |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| rsp_kind_i | input | 2 | 0 none, 1 short 48-bit, 2 or 3 long 136-bit |
| toggle_i | input | 1 | Completion tag latched with the fire |
| tmo_units_i | input | 12 | Reply wait limit in units of 16 clocks |
| cmd_o | output | 1 | Command line output value |
| cmd_oe_o | output | 1 | Command line drive enable |
| cmd_i | input | 1 | Command line input value |
| rsp_sel_i | input | 4 | Reply word select |
| rsp_word_o | output | 16 | Selected 16-bit reply word |
| status_o | output | 16 | Bit 0 idle, bit 1 ready, bit 2 timeout, bit 15 tag |

## Verification
The bench fires commands with four reply kinds: none, short, long, and the alternate long code. A behavioural model follows every bit of every frame and every reply word.

- Commands with known CRC bytes check the CRC arithmetic separately from the framing order.
- Patterned replies that arrive after different delays check where the start bit is found and how many bits the capture takes.
- Replies that never arrive, with wait limits of 0, 1 and the maximum, check the length of the wait window.
- Extra fire pulses during sending and during waiting check that a busy block ignores new commands.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  localparam int FRAME_W     = 48;
  localparam int HEAD_W      = 40;
  localparam int CRC_W       = 7;
  localparam int SHORT_RSP_W = 48;
  localparam int LONG_RSP_W  = 136;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_CAP  = 2'd3
  } cmd_state_e;

  localparam logic [1:0] KIND_NONE  = 2'd0;
  localparam logic [1:0] KIND_SHORT = 2'd1;

  // serial CRC7, x^7 + x^3 + 1, zero start, MSB first
  function automatic logic [CRC_W-1:0] crc7_of(input logic [HEAD_W-1:0] head);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = HEAD_W - 1; i >= 0; i--) begin
      fb = head[i] ^ c[CRC_W-1];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [FRAME_W-1:0] frame_of(input logic [5:0]  idx,
                                                  input logic [31:0] arg);
    logic [HEAD_W-1:0] head;
    head = {2'b01, idx, arg};
    return {head, crc7_of(head), 1'b1};
  endfunction

  function automatic logic [7:0] rsp_bits(input logic [1:0] kind);
    if (kind == KIND_NONE)       return 8'd0;
    else if (kind == KIND_SHORT) return 8'(SHORT_RSP_W);
    else                         return 8'(LONG_RSP_W);
  endfunction

endpackage

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer
  import sd_cmd_pkg::*;
(
  input  logic [5:0]         idx_i,
  input  logic [31:0]        arg_i,
  output logic [FRAME_W-1:0] frame_o
);
  always_comb frame_o = frame_of(idx_i, arg_i);
endmodule

// File: rtl/sd_wait_timer.sv
module sd_wait_timer #(
  parameter int TMO_W     = 12,
  parameter int UNIT_LOG2 = 4,
  localparam int CNT_W    = TMO_W + UNIT_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [TMO_W-1:0] units_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load_i)             cnt_q <= {units_i, {UNIT_LOG2{1'b0}}};
    else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q <= CNT_W'(1));

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q == 0) |=> (cnt_q == 0));
endmodule

// File: rtl/sd_rsp_shifter.sv
module sd_rsp_shifter #(
  parameter int RSP_W  = 136,
  parameter int WORD_W = 16,
  localparam int NWORDS = (RSP_W + WORD_W - 1) / WORD_W,
  localparam int SEL_W  = $clog2(NWORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [WORD_W-1:0] word_o
);
  logic [RSP_W-1:0]         rsp_q;
  logic [NWORDS*WORD_W-1:0] padded;
  logic [WORD_W-1:0]        words [NWORDS];

  always_ff @(posedge clk) begin
    if (rst || clr_i) rsp_q <= '0;
    else if (shift_i) rsp_q <= {rsp_q[RSP_W-2:0], bit_i};
  end

  assign padded = (NWORDS*WORD_W)'(rsp_q);

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    assign words[g] = padded[g*WORD_W +: WORD_W];
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NWORDS; i++)
      if (sel_i == SEL_W'(i)) word_o = words[i];
  end

  a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (rsp_q == '0));
endmodule

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer
  import sd_cmd_pkg::*;
#(
  parameter int TMO_W     = 12,
  parameter int UNIT_LOG2 = 4,
  parameter int WORD_W    = 16,
  localparam int NWORDS   = (LONG_RSP_W + WORD_W - 1) / WORD_W,
  localparam int SEL_W    = $clog2(NWORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  logic [5:0]        cmd_idx_i,
  input  logic [31:0]       cmd_arg_i,
  input  logic [1:0]        rsp_kind_i,
  input  logic              toggle_i,
  input  logic [TMO_W-1:0]  tmo_units_i,
  output logic              cmd_o,
  output logic              cmd_oe_o,
  input  logic              cmd_i,
  input  logic [SEL_W-1:0]  rsp_sel_i,
  output logic [WORD_W-1:0] rsp_word_o,
  output logic [15:0]       status_o
);
  localparam int BITCNT_W = $clog2(FRAME_W);

  cmd_state_e            state_q;
  logic [FRAME_W-1:0]    tx_q;
  logic [FRAME_W-1:0]    frame_w;
  logic [BITCNT_W-1:0]   bit_left_q;
  logic [7:0]            rsp_left_q;
  logic [1:0]            kind_q;
  logic                  toggle_q, ready_q, tmo_q;

  // named events
  logic fire_ok, send_done, start_seen, wait_expired, cap_done, timer_last, shift_en;

  assign fire_ok      = fire_i && (state_q == ST_IDLE);
  assign send_done    = (state_q == ST_SEND) && (bit_left_q == '0);
  assign start_seen   = (state_q == ST_WAIT) && !cmd_i;
  assign wait_expired = (state_q == ST_WAIT) && cmd_i && timer_last;
  assign cap_done     = (state_q == ST_CAP) && (rsp_left_q == 8'd1);
  assign shift_en     = start_seen || (state_q == ST_CAP);

  sd_cmd_framer u_framer (
    .idx_i   (cmd_idx_i),
    .arg_i   (cmd_arg_i),
    .frame_o (frame_w)
  );

  sd_wait_timer #(.TMO_W(TMO_W), .UNIT_LOG2(UNIT_LOG2)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load_i  (send_done),
    .units_i (tmo_units_i),
    .dec_i   (state_q == ST_WAIT),
    .last_o  (timer_last)
  );

  sd_rsp_shifter #(.RSP_W(LONG_RSP_W), .WORD_W(WORD_W)) u_rsp (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (fire_ok),
    .shift_i (shift_en),
    .bit_i   (cmd_i),
    .sel_i   (rsp_sel_i),
    .word_o  (rsp_word_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      tx_q       <= '0;
      bit_left_q <= '0;
      rsp_left_q <= '0;
      kind_q     <= KIND_NONE;
      toggle_q   <= 1'b0;
      ready_q    <= 1'b0;
      tmo_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fire_ok) begin
          tx_q       <= frame_w;
          bit_left_q <= BITCNT_W'(FRAME_W - 1);
          kind_q     <= rsp_kind_i;
          toggle_q   <= toggle_i;
          ready_q    <= 1'b0;
          tmo_q      <= 1'b0;
          state_q    <= ST_SEND;
        end
        ST_SEND: if (send_done) begin
          if (kind_q == KIND_NONE) begin
            ready_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_WAIT;
          end
        end else begin
          tx_q       <= {tx_q[FRAME_W-2:0], 1'b0};
          bit_left_q <= bit_left_q - 1'b1;
        end
        ST_WAIT: if (start_seen) begin
          rsp_left_q <= rsp_bits(kind_q) - 8'd1;
          state_q    <= ST_CAP;
        end else if (wait_expired) begin
          tmo_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_CAP: if (cap_done) begin
          ready_q <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          rsp_left_q <= rsp_left_q - 8'd1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_oe_o = (state_q == ST_IDLE) || (state_q == ST_SEND);
  assign cmd_o    = (state_q == ST_SEND) ? tx_q[FRAME_W-1] : 1'b1;
  assign status_o = {toggle_q, 12'd0, tmo_q, ready_q, state_q == ST_IDLE};

  a_r2_fire_starts_frame: assert property (@(posedge clk) disable iff (rst)
    fire_ok |=> (cmd_oe_o && !cmd_o));
  a_r9_busy_fire_ignored: assert property (@(posedge clk) disable iff (rst)
    (fire_i && !status_o[0]) |=> $stable(status_o[15]));
  a_r10_fire_clears_flags: assert property (@(posedge clk) disable iff (rst)
    fire_ok |=> (status_o[2:1] == 2'b00));
  a_r4_release_after_frame: assert property (@(posedge clk) disable iff (rst)
    (send_done && kind_q != KIND_NONE) |=> !cmd_oe_o);
  a_r7_none_completes: assert property (@(posedge clk) disable iff (rst)
    (send_done && kind_q == KIND_NONE) |=> (status_o[1:0] == 2'b11));
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(status_o[1] && status_o[2]));
  a_r5_timeout_from_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[2]) |-> $past(state_q == ST_WAIT));
  a_r6_ready_on_last_bit: assert property (@(posedge clk) disable iff (rst)
    cap_done |=> (status_o[1:0] == 2'b11));
endmodule

// File: tb/sd_cmd_issuer_tb.sv
module sd_cmd_issuer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fire = 1'b0;
  logic [5:0]  idx = '0;
  logic [31:0] arg = '0;
  logic [1:0]  kind = '0;
  logic        tgl = 1'b0;
  logic [11:0] tmo = '0;
  logic        cmd_o, cmd_oe;
  logic        cmd_line = 1'b1;
  logic [3:0]  sel = '0;
  logic [15:0] word;
  logic [15:0] status;

  always #10 clk = ~clk;

  sd_cmd_issuer u_dut (
    .clk(clk), .rst(rst), .fire_i(fire), .cmd_idx_i(idx), .cmd_arg_i(arg),
    .rsp_kind_i(kind), .toggle_i(tgl), .tmo_units_i(tmo),
    .cmd_o(cmd_o), .cmd_oe_o(cmd_oe), .cmd_i(cmd_line),
    .rsp_sel_i(sel), .rsp_word_o(word), .status_o(status)
  );

  int checks = 0, fails = 0, cyc = 0, low_oe_cnt = 0;
  bit card_q[$];
  bit tx_log[$];
  int unsigned rng = 32'h1234_5677;

  // behavioural reference
  int          m_st = 0;
  bit          m_q[$];
  int          m_wcnt = 0, m_rem = 0, m_kind = 0;
  logic [135:0] m_rsp = '0;
  bit          m_tgl = 0, m_rdy = 0, m_tmo = 0;

  function automatic logic [6:0] div_crc(input logic [39:0] d);
    logic [46:0] r;
    r = {d, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_st = 0; m_q.delete(); m_rsp = '0; m_tgl = 0; m_rdy = 0; m_tmo = 0; m_kind = 0;
    end else begin
      case (m_st)
        0: if (fire) begin
          logic [39:0] h;
          logic [47:0] f;
          h = {2'b01, idx, arg};
          f = {h, div_crc(h), 1'b1};
          for (int i = 47; i >= 0; i--) m_q.push_back(f[i]);
          m_kind = kind; m_tgl = tgl; m_rdy = 0; m_tmo = 0; m_rsp = '0; m_st = 1;
          m_wcnt = tmo * 16;
          if (m_wcnt < 1) m_wcnt = 1;
        end
        1: begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin
            if (m_kind == 0) begin m_rdy = 1; m_st = 0; end
            else m_st = 2;
          end
        end
        2: if (cmd_line == 1'b0) begin
          m_rsp = {m_rsp[134:0], 1'b0};
          m_rem = (m_kind == 1) ? 47 : 135;
          m_st = 3;
        end else begin
          m_wcnt--;
          if (m_wcnt == 0) begin m_tmo = 1; m_st = 0; end
        end
        default: begin
          m_rsp = {m_rsp[134:0], cmd_line};
          m_rem--;
          if (m_rem == 0) begin m_rdy = 1; m_st = 0; end
        end
      endcase
    end
    #2;
    cmd_line = (card_q.size() > 0) ? card_q.pop_front() : 1'b1;
    sel = 4'(cyc % 10);
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cyc >= 1 && !rst) begin
      logic        e_oe, e_cmd;
      logic [15:0] e_st, e_word;
      logic [143:0] pad;
      e_oe  = (m_st < 2);
      e_cmd = (m_st == 1) ? m_q[0] : 1'b1;
      e_st  = {m_tgl, 12'd0, m_tmo, m_rdy, m_st == 0};
      pad   = {8'd0, m_rsp};
      e_word = (sel <= 8) ? pad[sel*16 +: 16] : 16'd0;
      if (m_st == 1) tx_log.push_back(cmd_o);
      if (!cmd_oe) low_oe_cnt++;
      checks++;
      if (cmd_o !== e_cmd) begin fails++; $display("FAIL R2 cmd bit actual=%0h expected=%0h", cmd_o, e_cmd); end
      else if (cmd_oe !== e_oe) begin fails++; $display("FAIL R4 drive enable actual=%0h expected=%0h", cmd_oe, e_oe); end
      else if (status[0] !== e_st[0]) begin fails++; $display("FAIL R6 idle actual=%0h expected=%0h", status, e_st); end
      else if (status[1] !== e_st[1]) begin fails++; $display("FAIL R6 ready actual=%0h expected=%0h", status, e_st); end
      else if (status[2] !== e_st[2]) begin fails++; $display("FAIL R5 timeout actual=%0h expected=%0h", status, e_st); end
      else if (status !== e_st) begin fails++; $display("FAIL R8 status actual=%0h expected=%0h", status, e_st); end
      else if (word !== e_word) begin fails++; $display("FAIL R6 word%0d actual=%0h expected=%0h", sel, word, e_word); end
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic bit nextbit();
    rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
    return rng[7];
  endfunction

  task automatic do_fire(input logic [5:0] i, input logic [31:0] a, input logic [1:0] k,
                         input bit t, input logic [11:0] u);
    @(posedge clk); #3;
    idx = i; arg = a; kind = k; tgl = t; tmo = u; fire = 1'b1;
    tx_log.delete(); low_oe_cnt = 0;
    @(posedge clk); #3;
    fire = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!status[0]);
  endtask

  // delay < 0: card stays silent
  task automatic issue(input logic [5:0] i, input logic [31:0] a, input logic [1:0] k,
                       input bit t, input logic [11:0] u, input int delay);
    do_fire(i, a, k, t, u);
    if (k != 0 && delay >= 0) begin
      int n;
      do @(negedge clk); while (cmd_oe);
      n = (k == 1) ? 48 : 136;
      for (int d = 0; d < delay; d++) card_q.push_back(1'b1);
      card_q.push_back(1'b0);
      for (int b = 1; b < n; b++) card_q.push_back(nextbit());
    end
    wait_idle();
  endtask

  function automatic logic [7:0] last_byte();
    logic [7:0] v;
    v = '0;
    for (int b = 0; b < 8; b++) v = {v[6:0], logic'(tx_log[tx_log.size() - 8 + b])};
    return v;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #3 rst = 1'b0;
    @(negedge clk);
    chk(status == 16'h0001, "R1", "status", status, 16'h0001);
    chk(cmd_o && cmd_oe, "R1", "line", {cmd_o, cmd_oe}, 2'b11);
    chk(word == 16'h0, "R1", "reply word", word, 0);

    issue(6'd0, 32'h0, 2'd0, 1'b1, 12'd5, -1);
    chk(tx_log.size() == 48, "R2", "frame length", tx_log.size(), 48);
    chk(last_byte() == 8'h95, "R3", "crc byte cmd0", last_byte(), 8'h95);
    chk(status == 16'h8003, "R7", "status none kind", status, 16'h8003);
    chk(status[15] == 1'b1, "R8", "tag echo", status[15], 1);

    issue(6'd17, 32'h0, 2'd1, 1'b0, 12'd4, 3);
    chk(last_byte() == 8'h55, "R3", "crc byte cmd17", last_byte(), 8'h55);
    chk(status[2:0] == 3'b011, "R6", "short reply flags", status[2:0], 3'b011);
    chk(status[15] == 1'b0, "R8", "tag echo", status[15], 0);

    issue(6'd8, 32'h1AA, 2'd1, 1'b1, 12'd2, 0);
    chk(last_byte() == 8'h87, "R3", "crc byte cmd8", last_byte(), 8'h87);

    issue(6'd2, 32'h1234_5678, 2'd2, 1'b0, 12'd3, 10);
    chk(status[2:0] == 3'b011, "R6", "long reply flags", status[2:0], 3'b011);
    issue(6'd9, 32'hDEAD_BEEF, 2'd3, 1'b1, 12'd3, 5);
    chk(status[1] == 1'b1, "R6", "alt long ready", status[1], 1);

    issue(6'd13, 32'h0, 2'd1, 1'b0, 12'd1, -1);
    chk(low_oe_cnt == 16, "R4", "wait window T=1", low_oe_cnt, 16);
    chk(status[2:0] == 3'b101, "R5", "timeout flags", status[2:0], 3'b101);

    issue(6'd13, 32'h0, 2'd1, 1'b1, 12'd0, -1);
    chk(low_oe_cnt == 1, "R4", "wait window T=0", low_oe_cnt, 1);

    issue(6'd55, 32'hFFFF_FFFF, 2'd2, 1'b0, 12'hFFF, -1);
    chk(low_oe_cnt == 65520, "R4", "wait window max", low_oe_cnt, 65520);
    chk(status[2] == 1'b1, "R5", "timeout at max", status[2], 1);

    issue(6'd3, 32'h0, 2'd1, 1'b1, 12'd2, 1);
    chk(status[2:0] == 3'b011, "R10", "fire clears timeout", status[2:0], 3'b011);

    // busy fires during send and during wait
    do_fire(6'd7, 32'hA5A5_0F0F, 2'd1, 1'b1, 12'd3);
    repeat (5) @(posedge clk);
    #3 idx = 6'd63; tgl = 1'b0; kind = 2'd0; fire = 1'b1;
    @(posedge clk); #3 fire = 1'b0;
    do @(negedge clk); while (cmd_oe);
    @(posedge clk); #3 fire = 1'b1;
    @(posedge clk); #3 fire = 1'b0;
    wait_idle();
    chk(status[15] == 1'b1, "R9", "tag after busy fire", status[15], 1);
    chk(status[2:0] == 3'b101, "R9", "flags after busy fire", status[2:0], 3'b101);
    chk(tx_log.size() == 48, "R9", "frame length", tx_log.size(), 48);

    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule